// File: doc/BRIEF.md
# Condition Code Flag Generator

A purely combinational unit that produces the next value of an 8-bit condition code register for a processor with an 8-bit accumulator datapath and 16-bit register operations. The caller supplies the current flags, both operands, and the raw result of the operation. The raw result is one bit wider than the operand width, so the carry-out is visible. The caller also supplies an operation class, a width select and, for single-bit writes, a bit index. The block returns the updated flag byte. It also returns the signed less-than condition, taken from the updated flags, for the branch logic to use.

Each class rewrites only the flags it owns and passes every other bit through unchanged. Half carry and overflow are not taken from adder internals. They are recovered from the XOR of the two operands and the raw result, so any adder or subtractor can feed the block. The interrupt mask bits and the saved-state bit change only under an explicit set or clear.

Top module: `cc_flag_unit`

## Requirements
- R1: The flag byte layout is C=bit0, V=bit1, Z=bit2, N=bit3, I=bit4, H=bit5, F=bit6, E=bit7. The class codes on `cls_i` are 0 add, 1 subtract, 2 increment, 3 decrement, 4 load/logic, 5 set bit, 6 clear bit, 7 hold. `wide_i`=0 selects 8-bit operation and 1 selects 16-bit operation.
- R2: For an 8-bit add, the block rewrites H, N, Z, V and C:
  - H is bit 4 of a^b^r.
  - N is result bit 7.
  - Z is set when the result's low byte is zero.
  - V is bit 7 of a^b^r^(r>>1).
  - C is raw result bit 8.
- R3: A subtract rewrites N, Z, V and C with the same formulas at the selected width and leaves H unchanged. The caller supplies r = a - b, so C reports a borrow.
- R4: A 16-bit add or subtract uses bit 15 for N and V, the whole 16-bit result for Z, and raw bit 16 for C. H is left unchanged.
- R5: An increment rewrites only N, Z and V. An 8-bit result of 0x80 sets both N and V. Any result of 0x80 or above sets N, and 0x00 sets Z. At 16 bits, 0x8000 sets V. C and H are kept.
- R6: A decrement rewrites only N, Z and V. An 8-bit result of 0x7F sets V (0x7FFF at 16 bits). A result with the sign bit set sets N, and zero sets Z. C and H are kept.
- R7: A load/logic operation sets N and Z from the result, clears V, and keeps every other bit.
- R8: The set-bit and clear-bit classes force the flag at index `bit_sel_i` to 1 or 0 and leave the other seven bits unchanged.
- R9: The hold class returns `cc_i` unchanged.
- R10: `lt_o` equals N XOR V of the updated flags.
- R11: I, F and E never change in any class other than set bit and clear bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cc_i | input | 8 | Current flag byte |
| opa_i | input | 16 | First operand (low byte used in 8-bit mode) |
| opb_i | input | 16 | Second operand (low byte used in 8-bit mode) |
| res_i | input | 17 | Raw result including carry-out bit |
| cls_i | input | 3 | Operation class |
| wide_i | input | 1 | 0 = 8-bit, 1 = 16-bit |
| bit_sel_i | input | 3 | Flag index for set or clear |
| cc_o | output | 8 | Updated flag byte |
| lt_o | output | 1 | Signed less-than (N XOR V) of cc_o |

## Verification
The 8-bit add and subtract classes are swept over every operand pair. The incoming flag byte changes with the operands, so a mask that leaks shows up as a corrupted pass-through bit. This sweep also separates the XOR-derived overflow and half carry from an arithmetic sign-rule and nibble-sum model. Increment and decrement run over every byte and over the 16-bit sign boundaries; this isolates the 0x80 and 0x7F overflow corners and shows that C and H survive. The 16-bit vectors, the logic sweep, and the set/clear walk over all indices check, in turn, width selection, the forced V clear, and single-bit isolation.

// File: rtl/cc_flag_pkg.sv
package cc_flag_pkg;
   typedef enum logic [2:0] {
      CLS_ADD   = 3'd0,
      CLS_SUB   = 3'd1,
      CLS_INC   = 3'd2,
      CLS_DEC   = 3'd3,
      CLS_LOGIC = 3'd4,
      CLS_SETB  = 3'd5,
      CLS_CLRB  = 3'd6,
      CLS_HOLD  = 3'd7
   } cc_class_e;

   // flag positions inside the condition byte (R1)
   localparam int CCB_C = 0;
   localparam int CCB_V = 1;
   localparam int CCB_Z = 2;
   localparam int CCB_N = 3;
   localparam int CCB_I = 4;
   localparam int CCB_H = 5;
   localparam int CCB_F = 6;
   localparam int CCB_E = 7;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
      logic h;
      logic inc_v;
      logic dec_v;
   } flag_set_t;
endpackage

// File: rtl/cc_width_flags.sv
module cc_width_flags
   import cc_flag_pkg::*;
#(
   parameter int W      = 8,
   parameter int HC_BIT = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W:0]   r_i,
   output flag_set_t    fl_o
);
   localparam logic [W-1:0] SIGN_ONLY = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_POS   = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] r_trunc;
   logic [W-1:0] xsum;

   always_comb begin
      r_trunc     = r_i[W-1:0];
      xsum        = a_i ^ b_i ^ r_trunc;
      fl_o.n      = r_trunc[W-1];
      fl_o.z      = (r_trunc == '0);
      // carry into the top bit xor carry out of it
      fl_o.v      = xsum[W-1] ^ r_i[W];
      fl_o.c      = r_i[W];
      fl_o.h      = xsum[HC_BIT];
      fl_o.inc_v  = (r_trunc == SIGN_ONLY);
      fl_o.dec_v  = (r_trunc == MAX_POS);
   end
endmodule

// File: rtl/cc_merge.sv
module cc_merge
   import cc_flag_pkg::*;
#(
   parameter int CC_W  = 8,
   parameter int SEL_W = 3
) (
   input  logic [CC_W-1:0]  cc_i,
   input  logic [2:0]       cls_i,
   input  logic             wide_i,
   input  logic [SEL_W-1:0] bit_sel_i,
   input  flag_set_t        fl_i,
   output logic [CC_W-1:0]  cc_o
);
   logic [CC_W-1:0] own_mask;
   logic [CC_W-1:0] new_bits;
   logic [CC_W-1:0] one_hot;

   always_comb begin
      one_hot  = '0;
      one_hot[bit_sel_i] = 1'b1;
      own_mask = '0;
      new_bits = '0;
      new_bits[CCB_N] = fl_i.n;
      new_bits[CCB_Z] = fl_i.z;
      unique case (cc_class_e'(cls_i))
         CLS_ADD: begin
            own_mask[CCB_N] = 1'b1; own_mask[CCB_Z] = 1'b1;
            own_mask[CCB_V] = 1'b1; own_mask[CCB_C] = 1'b1;
            own_mask[CCB_H] = ~wide_i;
            new_bits[CCB_V] = fl_i.v;
            new_bits[CCB_C] = fl_i.c;
            new_bits[CCB_H] = fl_i.h;
         end
         CLS_SUB: begin
            own_mask[CCB_N] = 1'b1; own_mask[CCB_Z] = 1'b1;
            own_mask[CCB_V] = 1'b1; own_mask[CCB_C] = 1'b1;
            new_bits[CCB_V] = fl_i.v;
            new_bits[CCB_C] = fl_i.c;
         end
         CLS_INC: begin
            own_mask[CCB_N] = 1'b1; own_mask[CCB_Z] = 1'b1;
            own_mask[CCB_V] = 1'b1;
            new_bits[CCB_V] = fl_i.inc_v;
         end
         CLS_DEC: begin
            own_mask[CCB_N] = 1'b1; own_mask[CCB_Z] = 1'b1;
            own_mask[CCB_V] = 1'b1;
            new_bits[CCB_V] = fl_i.dec_v;
         end
         CLS_LOGIC: begin
            own_mask[CCB_N] = 1'b1; own_mask[CCB_Z] = 1'b1;
            own_mask[CCB_V] = 1'b1;
            new_bits[CCB_V] = 1'b0;
         end
         CLS_SETB: begin
            own_mask = one_hot;
            new_bits = one_hot;
         end
         CLS_CLRB: begin
            own_mask = one_hot;
            new_bits = '0;
         end
         default: begin
            own_mask = '0;
         end
      endcase
      cc_o = (cc_i & ~own_mask) | (new_bits & own_mask);
   end
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
   import cc_flag_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16,
   parameter int CC_W   = 8,
   parameter int HC_BIT = 4
) (
   input  logic [CC_W-1:0]         cc_i,
   input  logic [DATA_W-1:0]       opa_i,
   input  logic [DATA_W-1:0]       opb_i,
   input  logic [DATA_W:0]         res_i,
   input  logic [2:0]              cls_i,
   input  logic                    wide_i,
   input  logic [$clog2(CC_W)-1:0] bit_sel_i,
   output logic [CC_W-1:0]         cc_o,
   output logic                    lt_o
);
   localparam int SEL_W   = $clog2(CC_W);
   localparam int N_WIDTH = 2;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("DATA_W must be twice BYTE_W");
   end
   if (HC_BIT >= BYTE_W) begin : g_bad_hc
      $error("HC_BIT must lie inside the narrow operand");
   end
   if (CC_W != 8) begin : g_bad_cc
      $error("flag layout needs an 8-bit condition byte");
   end

   flag_set_t fl_w [N_WIDTH];
   flag_set_t fl_sel;

   for (genvar gi = 0; gi < N_WIDTH; gi++) begin : g_width
      localparam int LW = BYTE_W << gi;
      cc_width_flags #(.W(LW), .HC_BIT(HC_BIT)) flags_i (
         .a_i  (opa_i[LW-1:0]),
         .b_i  (opb_i[LW-1:0]),
         .r_i  (res_i[LW:0]),
         .fl_o (fl_w[gi])
      );
   end

   assign fl_sel = wide_i ? fl_w[1] : fl_w[0];

   cc_merge #(.CC_W(CC_W), .SEL_W(SEL_W)) merge_i (
      .cc_i      (cc_i),
      .cls_i     (cls_i),
      .wide_i    (wide_i),
      .bit_sel_i (bit_sel_i),
      .fl_i      (fl_sel),
      .cc_o      (cc_o)
   );

   assign lt_o = cc_o[CCB_N] ^ cc_o[CCB_V];
endmodule

// File: rtl/cc_flag_unit_chk.sv
module cc_flag_unit_chk
   import cc_flag_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16,
   parameter int CC_W   = 8
) (
   input logic [CC_W-1:0]         cc_i,
   input logic [DATA_W-1:0]       opa_i,
   input logic [DATA_W-1:0]       opb_i,
   input logic [DATA_W:0]         res_i,
   input logic [2:0]              cls_i,
   input logic                    wide_i,
   input logic [$clog2(CC_W)-1:0] bit_sel_i,
   input logic [CC_W-1:0]         cc_o,
   input logic                    lt_o
);
   logic known;
   assign known = !$isunknown({cc_i, opa_i, opb_i, res_i, cls_i, wide_i, bit_sel_i});

   always_comb begin
      if (known) begin
         // R2 R4: carry comes from the raw result bit above the width
         if (cls_i == CLS_ADD || cls_i == CLS_SUB)
            a_r2_carry_out: assert (cc_o[CCB_C] == (wide_i ? res_i[DATA_W] : res_i[BYTE_W]));
         // R9
         if (cls_i == CLS_HOLD)
            a_r9_hold: assert (cc_o == cc_i);
         // R11
         if (cls_i != CLS_SETB && cls_i != CLS_CLRB)
            a_r11_masks_kept: assert (cc_o[CCB_E] == cc_i[CCB_E] && cc_o[CCB_F] == cc_i[CCB_F]
                                      && cc_o[CCB_I] == cc_i[CCB_I]);
         // R5 R6: increment and decrement keep C and H
         if (cls_i == CLS_INC || cls_i == CLS_DEC)
            a_r5_step_keeps_ch: assert (cc_o[CCB_C] == cc_i[CCB_C] && cc_o[CCB_H] == cc_i[CCB_H]);
         // R7
         if (cls_i == CLS_LOGIC)
            a_r7_logic_v_clear: assert (!cc_o[CCB_V] && lt_o == cc_o[CCB_N]);
         // R8
         if (cls_i == CLS_SETB)
            a_r8_set_bit: assert (cc_o[bit_sel_i] && $countones(cc_o ^ cc_i) <= 1);
         if (cls_i == CLS_CLRB)
            a_r8_clr_bit: assert (!cc_o[bit_sel_i] && $countones(cc_o ^ cc_i) <= 1);
         // R1: Z and N cannot both be set from one result
         if (cls_i <= CLS_LOGIC)
            a_r1_z_excludes_n: assert (!(cc_o[CCB_Z] && cc_o[CCB_N]));
      end
   end
endmodule

bind cc_flag_unit cc_flag_unit_chk #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .CC_W(CC_W)) chk_i (.*);

// File: tb/cc_flag_unit_tb_top.sv
module cc_flag_unit_tb_top;
   import cc_flag_pkg::*;

   logic        clk = 1'b0;
   logic [7:0]  cc_i = 8'h00;
   logic [15:0] opa_i = '0;
   logic [15:0] opb_i = '0;
   logic [16:0] res_i = '0;
   logic [2:0]  cls_i = CLS_HOLD;
   logic        wide_i = 1'b0;
   logic [2:0]  bit_sel_i = '0;
   logic [7:0]  cc_o;
   logic        lt_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   cc_flag_unit dut_i (.*);

   // independent model built from signed-arithmetic rules
   function automatic logic [7:0] model(input logic [2:0] cls, input logic wd,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic [16:0] r, input logic [7:0] cc,
                                        input logic [2:0] sel);
      logic [7:0] e = cc;
      logic sa, sb, sr;
      logic [15:0] rt;
      rt = wd ? r[15:0] : {8'h00, r[7:0]};
      sa = wd ? a[15] : a[7];
      sb = wd ? b[15] : b[7];
      sr = wd ? rt[15] : rt[7];
      case (cls)
         CLS_ADD, CLS_SUB: begin
            e[3] = sr; e[2] = (rt == 0);
            e[0] = wd ? r[16] : r[8];
            if (cls == CLS_ADD) begin
               e[1] = (sa == sb) && (sr != sa);
               if (!wd) e[5] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            end else
               e[1] = (sa != sb) && (sr != sa);
         end
         CLS_INC: begin
            e[3] = sr; e[2] = (rt == 0);
            e[1] = wd ? (rt == 16'h8000) : (rt == 16'h0080);
         end
         CLS_DEC: begin
            e[3] = sr; e[2] = (rt == 0);
            e[1] = wd ? (rt == 16'h7FFF) : (rt == 16'h007F);
         end
         CLS_LOGIC: begin
            e[3] = sr; e[2] = (rt == 0); e[1] = 1'b0;
         end
         CLS_SETB: e[sel] = 1'b1;
         CLS_CLRB: e[sel] = 1'b0;
         default: e = cc;
      endcase
      return e;
   endfunction

   task automatic apply(input string req, input logic [2:0] cls, input logic wd,
                        input logic [15:0] a, input logic [15:0] b, input logic [16:0] r,
                        input logic [7:0] cc, input logic [2:0] sel);
      logic [7:0] exp_cc;
      logic exp_lt;
      @(posedge clk);
      cls_i = cls; wide_i = wd; opa_i = a; opb_i = b; res_i = r; cc_i = cc; bit_sel_i = sel;
      @(negedge clk);
      exp_cc = model(cls, wd, a, b, r, cc, sel);
      exp_lt = exp_cc[3] ^ exp_cc[1];   // R10
      checks++;
      if (cc_o !== exp_cc || lt_o !== exp_lt) begin
         errors++;
         $display("FAIL %s cls=%0d wide=%0b a=%04h b=%04h r=%05h cc_in=%02h: cc_o=%02h expected %02h, lt_o=%0b expected %0b",
                  req, cls, wd, a, b, r, cc, cc_o, exp_cc, lt_o, exp_lt);
      end
   endtask

   task automatic t_hold_initial();   // R9: state after start-up
      apply("R9", CLS_HOLD, 1'b0, 16'h0000, 16'h0000, 17'h0, 8'h00, 3'd0);
      apply("R9", CLS_HOLD, 1'b1, 16'h1234, 16'hFFFF, 17'h1FFFF, 8'hA5, 3'd7);
   endtask

   task automatic t_add8_sweep();   // R2 R10 R11
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            apply("R2", CLS_ADD, 1'b0, 16'(a), 16'(b), 17'(a + b), 8'(a ^ (b << 1)), 3'd0);
   endtask

   task automatic t_sub8_sweep();   // R3
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            apply("R3", CLS_SUB, 1'b0, 16'(a), 16'(b), 17'((a - b) & 9'h1FF), 8'(~a ^ b), 3'd0);
   endtask

   task automatic t_wide();   // R4
      logic [15:0] x = 16'hACE1;
      logic [15:0] y = 16'h1D2B;
      apply("R4", CLS_ADD, 1'b1, 16'h7FFF, 16'h0001, 17'h08000, 8'h00, 3'd0);
      apply("R4", CLS_ADD, 1'b1, 16'h8000, 16'h8000, 17'h10000, 8'h20, 3'd0);
      apply("R4", CLS_SUB, 1'b1, 16'h0000, 16'h0001, 17'h1FFFF, 8'hFF, 3'd0);
      apply("R4", CLS_SUB, 1'b1, 16'h8000, 16'h0001, 17'h07FFF, 8'h00, 3'd0);
      for (int i = 0; i < 400; i++) begin
         x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
         y = {y[14:0], y[15] ^ y[13] ^ y[12] ^ y[10]};
         apply("R4", CLS_ADD, 1'b1, x, y, {1'b0, x} + {1'b0, y}, x[7:0], 3'd0);
         apply("R4", CLS_SUB, 1'b1, x, y, {1'b0, x} - {1'b0, y}, y[15:8], 3'd0);
      end
   endtask

   task automatic t_incdec();   // R5 R6
      for (int a = 0; a < 256; a++) begin
         apply("R5", CLS_INC, 1'b0, 16'(a), 16'h0001, 17'((a + 1) & 9'h1FF), 8'(a * 37), 3'd0);
         apply("R6", CLS_DEC, 1'b0, 16'(a), 16'h0001, 17'((a - 1) & 9'h1FF), 8'(a * 91), 3'd0);
      end
      apply("R5", CLS_INC, 1'b1, 16'h7FFF, 16'h0001, 17'h08000, 8'h21, 3'd0);
      apply("R5", CLS_INC, 1'b1, 16'hFFFF, 16'h0001, 17'h10000, 8'h08, 3'd0);
      apply("R6", CLS_DEC, 1'b1, 16'h8000, 16'h0001, 17'h07FFF, 8'h0D, 3'd0);
      apply("R6", CLS_DEC, 1'b1, 16'h0001, 16'h0001, 17'h00000, 8'hF0, 3'd0);
   endtask

   task automatic t_logic();   // R7
      for (int r = 0; r < 256; r++)
         apply("R7", CLS_LOGIC, 1'b0, 16'(r), 16'h00FF, 17'(r | 9'h100), 8'(~r), 3'd0);
      apply("R7", CLS_LOGIC, 1'b1, 16'h0, 16'h0, 17'h08001, 8'h02, 3'd0);
      apply("R7", CLS_LOGIC, 1'b1, 16'h0, 16'h0, 17'h10000, 8'hFF, 3'd0);
   endtask

   task automatic t_bits();   // R8 R11
      for (int s = 0; s < 8; s++) begin
         apply("R8", CLS_SETB, 1'b0, 16'h0, 16'h0, 17'h0, 8'h00, 3'(s));
         apply("R8", CLS_SETB, 1'b1, 16'h0, 16'h0, 17'h0, 8'h5A, 3'(s));
         apply("R8", CLS_CLRB, 1'b0, 16'h0, 16'h0, 17'h0, 8'hFF, 3'(s));
         apply("R8", CLS_CLRB, 1'b0, 16'h0, 16'h0, 17'h0, 8'hA5, 3'(s));
      end
   endtask

   initial begin
      t_hold_initial();
      t_add8_sweep();
      t_sub8_sweep();
      t_wide();
      t_incdec();
      t_logic();
      t_bits();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule